// File: doc/BRIEF.md
# Conversion Command Queue Controller

This block walks a table of conversion command words and drives an external converter sequencer. Every word selects one analog input channel and carries its sample-time code, a flag to bypass the sample amplifier, and a pause flag. The table is shared by two queues. Queue 1 occupies the entries from index 0 up to a programmable split index. Queue 2 occupies the entries from the split index to the top of the table. Channel code 63 ends a queue early, and that entry is never converted.

Each queue has its own trigger and its own scan mode. For every command the controller raises a one-cycle conversion request that carries the command's fields. It then waits for end of conversion, and writes the returned result to the result table at the index of the command that produced it. A word with its pause flag set closes a subqueue: the queue stops after that conversion and picks up at the next entry on its next trigger. Queue 1 always wins arbitration. Queue 2 yields to it between conversions and continues where it stopped once queue 1 goes idle.

Timing: a trigger sampled on one clock edge makes `conv_req` rise after the next edge. An end of conversion sampled on an edge makes `res_wr` rise after that same edge.

Top module: `cmdq_ctrl`

## Requirements
- R1: A write on `cmd_we` stores `cmd_data` at `cmd_addr` in the command table. The command word layout is: bits [5:0] channel, bits [7:6] sample-time code, bit [8] amplifier bypass, bit [9] pause. Later conversions of that entry use the written fields.
- R2: A trigger is taken only while the queue's mode is nonzero. Mode codes: 0 off, 1 single scan, 2 continuous scan, 3 behaves as single scan. A trigger for a queue in mode 0 starts no conversion and writes no result.
- R3: For each command the block raises `conv_req` for exactly one cycle, with `conv_chan`, `conv_samp` and `conv_byp` taken from the entry. It issues no further request until `conv_eoc` has been seen.
- R4: Queue 1 covers indices 0 to `q2_base`-1, and queue 2 covers `q2_base` to 63. A queue ends when its index reaches its limit or when it meets an entry with channel 63. That entry is never converted.
- R5: On `conv_eoc`, `res_wr` pulses for one cycle. `res_idx` carries the index of the command that produced the result, and `res_val` carries `conv_result`.
- R6: After converting an entry with its pause bit set, the queue pulses its pause output and halts. Its next trigger resumes it at the following entry.
- R7: When a queue reaches its end, it pulses its done output for one cycle and returns to its first entry. In single-scan mode it then waits for a trigger. In continuous mode it restarts at once.
- R8: Queue 1 has priority. If queue 1 becomes pending while queue 2 is running, queue 2 finishes its current conversion and is suspended. It later resumes at its next entry.
- R9: While reset is held, every output is low and both queues are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command table write strobe |
| cmd_addr | input | 6 | Command table write index |
| cmd_data | input | 10 | Command word to store |
| q1_mode | input | 2 | Scan mode of queue 1 |
| q2_mode | input | 2 | Scan mode of queue 2 |
| q2_base | input | 6 | First index of queue 2, end limit of queue 1 |
| q1_trig | input | 1 | Trigger for queue 1 |
| q2_trig | input | 1 | Trigger for queue 2 |
| conv_req | output | 1 | One-cycle start-of-conversion request |
| conv_chan | output | 6 | Channel to convert |
| conv_samp | output | 2 | Sample-time code |
| conv_byp | output | 1 | Bypass the sample amplifier |
| conv_eoc | input | 1 | End of conversion from the sequencer |
| conv_result | input | 10 | Conversion result, valid with `conv_eoc` |
| res_wr | output | 1 | Result table write strobe |
| res_idx | output | 6 | Result table index |
| res_val | output | 10 | Result value |
| q1_pause | output | 1 | Queue 1 reached a pause entry |
| q1_done | output | 1 | Queue 1 reached its end |
| q2_pause | output | 1 | Queue 2 reached a pause entry |
| q2_done | output | 1 | Queue 2 reached its end |

## Verification
The bench builds the block with the full 64-entry table and a 10-bit result. This puts a split index of 60 within reach, so queue 2 ends by running past index 63 rather than at an end marker. With the split index at 8, the bench covers the pause inside queue 1, an end marker inside queue 2, continuous rescans of queue 2, and queue 1 preempting queue 2. A reference model in the bench follows both queues cycle by cycle, and every output is compared on every clock.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
   localparam int CHAN_W = 6;
   localparam int SAMP_W = 2;

   typedef struct packed {
      logic              hold;
      logic              byp;
      logic [SAMP_W-1:0] samp;
      logic [CHAN_W-1:0] chan;
   } cmd_t;

   localparam int CMD_W = $bits(cmd_t);

   typedef enum logic [1:0] {
      MODE_OFF  = 2'd0,
      MODE_ONCE = 2'd1,
      MODE_SCAN = 2'd2
   } mode_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_CONV = 1'b1
   } seq_state_e;
endpackage

// File: rtl/cmdq_table.sv
module cmdq_table
   import cmdq_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  cmd_t             wdata,
   input  logic [IDX_W-1:0] raddr,
   output cmd_t             rdata
);
   cmd_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/cmdq_queue.sv
module cmdq_queue #(
   parameter int PTR_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             trig,
   input  logic             clr,
   input  logic             adv,
   input  logic             rewind,
   output logic             pend,
   output logic [PTR_W-1:0] ofs
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         ofs  <= '0;
      end else begin
         pend <= (pend & ~clr) | (trig & active);
         if (rewind)   ofs <= '0;
         else if (adv) ofs <= ofs + 1'b1;
      end
   end
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
   import cmdq_pkg::*;
#(
   parameter int IDX_W = 6,
   parameter int PTR_W = 7,
   parameter int RES_W = 10,
   parameter logic [CHAN_W-1:0] END_CODE = '1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            pend,
   input  logic [1:0]            active,
   input  logic [1:0]            rescan,
   input  logic [1:0][PTR_W-1:0] idx,
   input  logic [1:0][PTR_W-1:0] lim,
   output logic [IDX_W-1:0]      rd_addr,
   input  cmd_t                  rd_cmd,
   input  logic                  conv_eoc,
   input  logic [RES_W-1:0]      conv_result,
   output logic [1:0]            clr,
   output logic [1:0]            adv,
   output logic [1:0]            rewind,
   output logic                  conv_req,
   output logic [CHAN_W-1:0]     conv_chan,
   output logic [SAMP_W-1:0]     conv_samp,
   output logic                  conv_byp,
   output logic                  res_wr,
   output logic [IDX_W-1:0]      res_idx,
   output logic [RES_W-1:0]      res_val,
   output logic [1:0]            done,
   output logic [1:0]            pause
);
   seq_state_e       state;
   logic             cur_q;
   logic             cur_hold;
   logic [IDX_W-1:0] cur_idx;
   logic             sel_v;
   logic             sel;
   logic [PTR_W-1:0] sel_idx;
   logic             at_end;

   // queue 1 wins whenever it is pending and enabled
   always_comb begin
      sel_v   = (pend[0] & active[0]) | (pend[1] & active[1]);
      sel     = ~(pend[0] & active[0]);
      sel_idx = idx[sel];
      rd_addr = sel_idx[IDX_W-1:0];
      at_end  = (sel_idx >= lim[sel]) || (rd_cmd.chan == END_CODE);
   end

   always_comb begin
      clr    = '0;
      adv    = '0;
      rewind = '0;
      if (state == ST_IDLE && sel_v && at_end) begin
         rewind[sel] = 1'b1;
         clr[sel]    = ~rescan[sel];
      end
      if (state == ST_CONV && conv_eoc) begin
         adv[cur_q] = 1'b1;
         clr[cur_q] = cur_hold;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_q     <= 1'b0;
         cur_hold  <= 1'b0;
         cur_idx   <= '0;
         conv_req  <= 1'b0;
         conv_chan <= '0;
         conv_samp <= '0;
         conv_byp  <= 1'b0;
         res_wr    <= 1'b0;
         res_idx   <= '0;
         res_val   <= '0;
         done      <= '0;
         pause     <= '0;
      end else begin
         conv_req <= 1'b0;
         res_wr   <= 1'b0;
         done     <= '0;
         pause    <= '0;
         case (state)
            ST_IDLE: begin
               if (sel_v) begin
                  if (at_end) begin
                     done[sel] <= 1'b1;
                  end else begin
                     conv_req  <= 1'b1;
                     conv_chan <= rd_cmd.chan;
                     conv_samp <= rd_cmd.samp;
                     conv_byp  <= rd_cmd.byp;
                     cur_q     <= sel;
                     cur_idx   <= rd_addr;
                     cur_hold  <= rd_cmd.hold;
                     state     <= ST_CONV;
                  end
               end
            end
            ST_CONV: begin
               if (conv_eoc) begin
                  res_wr       <= 1'b1;
                  res_idx      <= cur_idx;
                  res_val      <= conv_result;
                  pause[cur_q] <= cur_hold;
                  state        <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
   import cmdq_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int RES_W = 10,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PTR_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [IDX_W-1:0]  cmd_addr,
   input  logic [CMD_W-1:0]  cmd_data,
   input  logic [1:0]        q1_mode,
   input  logic [1:0]        q2_mode,
   input  logic [IDX_W-1:0]  q2_base,
   input  logic              q1_trig,
   input  logic              q2_trig,
   output logic              conv_req,
   output logic [CHAN_W-1:0] conv_chan,
   output logic [SAMP_W-1:0] conv_samp,
   output logic              conv_byp,
   input  logic              conv_eoc,
   input  logic [RES_W-1:0]  conv_result,
   output logic              res_wr,
   output logic [IDX_W-1:0]  res_idx,
   output logic [RES_W-1:0]  res_val,
   output logic              q1_pause,
   output logic              q1_done,
   output logic              q2_pause,
   output logic              q2_done
);
   localparam logic [CHAN_W-1:0] END_CODE = '1;

   generate
      if (DEPTH < 4 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("cmdq_ctrl: DEPTH must be a power of two of at least 4");
      end
      if (RES_W < 1) begin : g_bad_res
         $error("cmdq_ctrl: RES_W must be positive");
      end
   endgenerate

   logic [1:0]            pend, active, rescan, trig;
   logic [1:0]            clr, adv, rewind, done, pause;
   logic [1:0][PTR_W-1:0] ofs, idx, lim;
   logic [1:0][1:0]       mode;
   logic [IDX_W-1:0]      rd_addr;
   cmd_t                  rd_cmd;

   assign mode = {q2_mode, q1_mode};
   assign trig = {q2_trig, q1_trig};
   assign idx[0] = ofs[0];
   assign idx[1] = {1'b0, q2_base} + ofs[1];
   assign lim[0] = {1'b0, q2_base};
   assign lim[1] = PTR_W'(DEPTH);

   cmdq_table #(.DEPTH(DEPTH)) u_table (
      .clk   (clk),
      .we    (cmd_we),
      .waddr (cmd_addr),
      .wdata (cmd_t'(cmd_data)),
      .raddr (rd_addr),
      .rdata (rd_cmd)
   );

   for (genvar q = 0; q < 2; q++) begin : g_queue
      assign active[q] = (mode[q] != MODE_OFF);
      assign rescan[q] = (mode[q] == MODE_SCAN);
      cmdq_queue #(.PTR_W(PTR_W)) u_queue (
         .clk    (clk),
         .rst_n  (rst_n),
         .active (active[q]),
         .trig   (trig[q]),
         .clr    (clr[q]),
         .adv    (adv[q]),
         .rewind (rewind[q]),
         .pend   (pend[q]),
         .ofs    (ofs[q])
      );
   end

   cmdq_seq #(
      .IDX_W    (IDX_W),
      .PTR_W    (PTR_W),
      .RES_W    (RES_W),
      .END_CODE (END_CODE)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .pend        (pend),
      .active      (active),
      .rescan      (rescan),
      .idx         (idx),
      .lim         (lim),
      .rd_addr     (rd_addr),
      .rd_cmd      (rd_cmd),
      .conv_eoc    (conv_eoc),
      .conv_result (conv_result),
      .clr         (clr),
      .adv         (adv),
      .rewind      (rewind),
      .conv_req    (conv_req),
      .conv_chan   (conv_chan),
      .conv_samp   (conv_samp),
      .conv_byp    (conv_byp),
      .res_wr      (res_wr),
      .res_idx     (res_idx),
      .res_val     (res_val),
      .done        (done),
      .pause       (pause)
   );

   assign q1_done  = done[0];
   assign q2_done  = done[1];
   assign q1_pause = pause[0];
   assign q2_pause = pause[1];
endmodule

// File: rtl/cmdq_chk.sv
module cmdq_chk
   import cmdq_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              conv_req,
   input logic [CHAN_W-1:0] conv_chan,
   input logic              conv_eoc,
   input logic              res_wr,
   input logic              q1_pause,
   input logic              q1_done,
   input logic              q2_pause,
   input logic              q2_done
);
   localparam logic [CHAN_W-1:0] END_CODE = '1;

   a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |=> !conv_req);

   a_r4_end_not_issued: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> conv_chan != END_CODE);

   a_r5_wr_after_eoc: assert property (@(posedge clk) disable iff (!rst_n)
      res_wr |-> $past(conv_eoc));

   a_r5_wr_not_with_req: assert property (@(posedge clk) disable iff (!rst_n)
      res_wr |-> !conv_req);

   a_r6_pause_with_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (q1_pause || q2_pause) |-> res_wr);

   a_r7_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({q1_done, q2_done, q1_pause, q2_pause}));
endmodule

bind cmdq_ctrl cmdq_chk u_chk (.*);

// File: tb/sim_cmdq_ctrl.sv
`timescale 1ns/1ps
module sim_cmdq_ctrl;
   import cmdq_pkg::*;
   localparam int DEPTH = 64;
   localparam int RES_W = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_we = 1'b0;
   logic [5:0] cmd_addr = '0;
   logic [CMD_W-1:0] cmd_data = '0;
   logic [1:0] q1_mode = '0, q2_mode = '0;
   logic [5:0] q2_base = '0;
   logic q1_trig = 1'b0, q2_trig = 1'b0;
   logic conv_req, conv_byp, res_wr, q1_pause, q1_done, q2_pause, q2_done;
   logic [5:0] conv_chan, res_idx;
   logic [1:0] conv_samp;
   logic conv_eoc = 1'b0;
   logic [RES_W-1:0] conv_result = '0, res_val;

   cmdq_ctrl #(.DEPTH(DEPTH), .RES_W(RES_W)) u0 (.*);

   always #2.5 clk = ~clk;

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // converter sequencer stand-in: end of conversion 4 cycles after request
   int lat = 0, nconv = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         lat = 0;
         conv_eoc <= 1'b0;
      end else begin
         conv_eoc <= 1'b0;
         if (conv_req) lat = 3;
         else if (lat > 0) begin
            lat--;
            if (lat == 0) begin
               conv_eoc    <= 1'b1;
               conv_result <= RES_W'(int'(conv_chan) * 13 + nconv);
               nconv++;
            end
         end
      end
   end

   // behavioural reference model
   int t_chan[DEPTH], t_samp[DEPTH], t_byp[DEPTH], t_hold[DEPTH];
   int m_busy = 0, m_q = 0, m_idx = 0, m_hold = 0;
   int m_pend[2], m_ofs[2];
   int e_req = 0, e_chan = 0, e_samp = 0, e_byp = 0, e_wr = 0, e_idx = 0, e_val = 0;
   int e_done[2], e_pause[2];

   always @(posedge clk) begin
      int clr[2], mode[2], trg[2], s, ix, start, limit;
      mode[0] = q1_mode; mode[1] = q2_mode;
      trg[0] = q1_trig;  trg[1] = q2_trig;
      if (!rst_n) begin
         m_busy = 0; m_q = 0; m_idx = 0; m_hold = 0;
         e_req = 0; e_chan = 0; e_samp = 0; e_byp = 0; e_wr = 0; e_idx = 0; e_val = 0;
         for (int q = 0; q < 2; q++) begin
            m_pend[q] = 0; m_ofs[q] = 0; e_done[q] = 0; e_pause[q] = 0;
         end
      end else begin
         clr[0] = 0; clr[1] = 0;
         e_req = 0; e_wr = 0;
         for (int q = 0; q < 2; q++) begin e_done[q] = 0; e_pause[q] = 0; end
         if (!m_busy) begin
            s = -1;
            if (m_pend[0] != 0 && mode[0] != 0) s = 0;
            else if (m_pend[1] != 0 && mode[1] != 0) s = 1;
            if (s >= 0) begin
               start = (s == 0) ? 0 : int'(q2_base);
               limit = (s == 0) ? int'(q2_base) : DEPTH;
               ix = start + m_ofs[s];
               if (ix >= limit || t_chan[ix] == 63) begin
                  e_done[s] = 1;
                  m_ofs[s] = 0;
                  if (mode[s] != 2) clr[s] = 1;
               end else begin
                  e_req = 1; e_chan = t_chan[ix]; e_samp = t_samp[ix]; e_byp = t_byp[ix];
                  m_q = s; m_idx = ix; m_hold = t_hold[ix]; m_busy = 1;
               end
            end
         end else if (conv_eoc) begin
            e_wr = 1; e_idx = m_idx; e_val = int'(conv_result);
            m_ofs[m_q]++;
            if (m_hold != 0) begin e_pause[m_q] = 1; clr[m_q] = 1; end
            m_busy = 0;
         end
         for (int q = 0; q < 2; q++)
            m_pend[q] = ((m_pend[q] != 0 && clr[q] == 0) || (trg[q] != 0 && mode[q] != 0)) ? 1 : 0;
      end
      if (cmd_we) begin
         t_chan[cmd_addr] = int'(cmd_data[5:0]);
         t_samp[cmd_addr] = int'(cmd_data[7:6]);
         t_byp[cmd_addr]  = int'(cmd_data[8]);
         t_hold[cmd_addr] = int'(cmd_data[9]);
      end
   end

   // per-cycle comparison and scenario statistics
   int n_wr, n_hi, n_12, last_idx, first_idx, rec, win, viol, nreq, req2_chan;
   int evc[4];
   always @(negedge clk) begin
      if (rst_n) begin
         chk(conv_req == e_req[0], "R3 conv_req", conv_req, e_req);
         if (e_req != 0) begin
            chk(conv_chan == e_chan[5:0], "R1 conv_chan", conv_chan, e_chan);
            chk(conv_samp == e_samp[1:0] && conv_byp == e_byp[0], "R1 samp/byp",
                {conv_samp, conv_byp}, e_samp * 2 + e_byp);
         end
         chk(res_wr == e_wr[0], "R5 res_wr", res_wr, e_wr);
         if (e_wr != 0) begin
            chk(res_idx == e_idx[5:0], "R5 res_idx", res_idx, e_idx);
            chk(res_val == e_val[RES_W-1:0], "R5 res_val", res_val, e_val);
         end
         chk(q1_pause == e_pause[0][0] && q2_pause == e_pause[1][0], "R6 pause pulses",
             {q1_pause, q2_pause}, e_pause[0] * 2 + e_pause[1]);
         chk(q1_done == e_done[0][0] && q2_done == e_done[1][0], "R7 done pulses",
             {q1_done, q2_done}, e_done[0] * 2 + e_done[1]);
      end
      if (conv_req) begin
         nreq++;
         if (nreq == 2) req2_chan = conv_chan;
      end
      if (res_wr) begin
         n_wr++;
         last_idx = res_idx;
         if (res_idx >= q2_base) n_hi++;
         if (res_idx == 6'd12) n_12++;
         if (win != 0 && res_idx >= q2_base) viol++;
         if (rec != 0) begin first_idx = res_idx; rec = 0; end
         if (res_idx < q2_base && !q1_pause) win = 1;
      end
      if (q1_pause) begin evc[0]++; win = 0; end
      if (q1_done)  evc[1]++;
      if (q2_pause) evc[2]++;
      if (q2_done)  evc[3]++;
   end

   task automatic clr_stats();
      n_wr = 0; n_hi = 0; n_12 = 0; last_idx = -1; first_idx = -1; rec = 0;
      win = 0; viol = 0; nreq = 0; req2_chan = -1;
      for (int k = 0; k < 4; k++) evc[k] = 0;
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk); #1 rst_n = 1'b0;
      cycles(2);
      chk(!conv_req && !res_wr && !q1_pause && !q1_done && !q2_pause && !q2_done,
          "R9 outputs low in reset", {conv_req, res_wr, q1_pause, q1_done, q2_pause, q2_done}, 0);
      rst_n = 1'b1;
      clr_stats();
   endtask

   task automatic put_cmd(input int a, input int ch, input int sp, input int bp, input int hd);
      @(negedge clk); #1;
      cmd_we = 1'b1; cmd_addr = 6'(a);
      cmd_data = {1'(hd), 1'(bp), 2'(sp), 6'(ch)};
      @(negedge clk); #1 cmd_we = 1'b0;
   endtask

   task automatic trig(input int q);
      @(negedge clk); #1;
      if (q == 0) q1_trig = 1'b1; else q2_trig = 1'b1;
      @(negedge clk); #1;
      q1_trig = 1'b0; q2_trig = 1'b0;
   endtask

   task automatic wait_ev(input int kind);
      int base = evc[kind];
      int t = 0;
      while (evc[kind] == base && t < 2000) begin @(negedge clk); t++; end
      #1;
   endtask

   bit finished = 0;
   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      clr_stats();
      // table: pause at 3, end marker at 12
      for (int i = 0; i < DEPTH; i++)
         put_cmd(i, (i == 12) ? 63 : (i % 50) + 1, i % 4, (i >> 1) & 1, (i == 3) ? 1 : 0);

      // scenario A: queue 1 single scan with a pause, queue 2 off
      q2_base = 6'd8; q1_mode = 2'd1; q2_mode = 2'd0;
      do_reset();
      trig(1);
      cycles(30);
      chk(n_wr == 0, "R2 mode-0 trigger ignored", n_wr, 0);
      trig(0);
      wait_ev(0);
      chk(n_wr == 4, "R6 halt at pause entry", n_wr, 4);
      cycles(20);
      chk(n_wr == 4, "R6 stays halted", n_wr, 4);
      rec = 1;
      trig(0);
      wait_ev(1);
      chk(first_idx == 4, "R6 resume at next entry", first_idx, 4);
      chk(n_wr == 8 && last_idx == 7, "R4 queue 1 ends at split index", last_idx, 7);
      chk(evc[1] == 1, "R7 one done pulse", evc[1], 1);
      chk(n_hi == 0, "R2 no queue 2 results", n_hi, 0);

      // scenario B: queue 2 continuous, queue 1 preempts
      q1_mode = 2'd1; q2_mode = 2'd2;
      do_reset();
      trig(1);
      cycles(80);
      chk(evc[3] >= 2, "R7 continuous rescan", evc[3], 2);
      trig(0);
      wait_ev(0);
      begin
         int hi_at_pause = n_hi;
         cycles(40);
         chk(n_hi > hi_at_pause, "R8 queue 2 resumes", n_hi, hi_at_pause + 1);
      end
      chk(viol == 0, "R8 queue 2 held during queue 1", viol, 0);
      chk(n_12 == 0, "R4 end marker not converted", n_12, 0);

      // scenario C: split at 60, queue 2 runs off the table top
      q2_base = 6'd60; q1_mode = 2'd0; q2_mode = 2'd1;
      put_cmd(61, 40, 3, 1, 0);
      do_reset();
      trig(1);
      wait_ev(3);
      chk(n_wr == 4 && last_idx == 63, "R4 queue 2 ends past index 63", last_idx, 63);
      chk(req2_chan == 40, "R1 rewritten entry used", req2_chan, 40);
      cycles(20);
      chk(n_wr == 4, "R7 single scan stops", n_wr, 4);
      rec = 1;
      trig(1);
      cycles(10);
      chk(first_idx == 60, "R7 restart at first entry", first_idx, 60);
      cycles(40);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule